// File: doc/BRIEF.md
# Dual-Rail Lookahead Adder/Subtractor

This block is the arithmetic half of an N-bit ALU. Every operand-derived bit, every carry and every result bit travels as a pair of wires: a true wire and a false wire. A consumer can therefore tell a resolved result from one that is still settling. Each bit slice turns its operand bits into a gated propagate term, a gated kill term and two generate terms, one for each carry value. A lookahead network then expands both carry rails in parallel from those terms and the carry-in. No carry ripples from slice to slice.

When the caller drives `go` high with `arith_mode` high, the unit computes `op_a + op_b`, or `op_a - op_b` when `add_sub` is high. The result appears on registered dual-rail outputs one clock later, and `done` goes high. If either `go` or `arith_mode` is low, the gating inside every slice holds every rail at null. Registers load these null rails on the next edge, so no false sum or false carry can leave the block during a logic operation. A two-state phase machine tracks whether the output register holds a result. It has two states. `ST_IDLE` means the registers hold null. `ST_RESULT` means the registers hold a computed result. There are two transitions. `start`, from `ST_IDLE` to `ST_RESULT`, occurs on an edge where `go & arith_mode` is high. `release`, from `ST_RESULT` to `ST_IDLE`, occurs on an edge where it is low. While enabled, the machine stays in `ST_RESULT` and takes a new result on every edge.

Top module: `dr_addsub_cla`

## Requirements
- R1: With `add_sub`=1 the result is `op_a + ~op_b + 1` taken modulo 2^WIDTH, which is the two's-complement difference. `cout` is true when no borrow occurs, that is, when `op_a >= op_b` unsigned.
- R2: With `add_sub`=0 the sum rails carry `(op_a + op_b)` mod 2^WIDTH and the carry-out carries bit WIDTH of the full sum.
- R3: Each bit uses the pair {true, false}. The code 10 means logic 1, 01 means logic 0 and 00 means null. The code 11 never appears on any sum, carry-out or internal carry pair.
- R4: After an edge that samples `go` low, every sum rail, both carry-out rails and `done` are 0.
- R5: After an edge that samples `arith_mode` low, every sum rail, both carry-out rails and `done` are 0, even when `go` is high.
- R6: `done` is 1 exactly when the phase machine is in `ST_RESULT` and every sum pair and the carry-out pair hold 10 or 01.
- R7: The result for inputs sampled at an edge is present on the outputs right after that edge. A new operation on each following edge replaces it with no idle cycle.
- R8: While `rst_n` is low, all rails are 0, `done` is 0 and the phase machine is in `ST_IDLE`.
- R9: A carry generated in bit 0 reaches the carry-out through every propagating bit. For example, FF+01 gives sum 00 with carry 1, and 7F-7F gives sum 00 with carry 1.
- R10: The phase machine enters `ST_RESULT` only on an edge where `go & arith_mode` is high, and it leaves on the first edge where that term is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Operation enable |
| arith_mode | input | 1 | High selects an arithmetic operation |
| add_sub | input | 1 | 0 = add, 1 = subtract |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| sum_t | output | WIDTH | Sum true rails |
| sum_f | output | WIDTH | Sum false rails |
| cout_t | output | 1 | Carry-out true rail |
| cout_f | output | 1 | Carry-out false rail |
| done | output | 1 | All outputs resolved |

## Verification
Every result, the null outputs and `done` are due exactly one rising edge after the inputs are sampled. The only register between the inputs and the ports is the output stage. The bench changes inputs on a falling edge and compares the outputs on the next falling edge, so exactly one rising edge lies between stimulus and check. Back-to-back vectors are applied on successive falling edges, and each check still lands one edge after its own stimulus.

// File: rtl/dr_addsub_pkg.sv
package dr_addsub_pkg;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } phase_e;

    // Rail pair: bit 1 = true wire, bit 0 = false wire.
    typedef logic [1:0] rail_t;

    localparam rail_t RAIL_NULL = 2'b00;
    localparam rail_t RAIL_ZERO = 2'b01;
    localparam rail_t RAIL_ONE  = 2'b10;

endpackage

// File: rtl/drcla_slice.sv
module drcla_slice (
    input  logic a_bit,
    input  logic b_bit,
    input  logic sub,
    input  logic en,
    output logic p_mod,
    output logic k_mod,
    output logic g_one,
    output logic g_zero
);
    logic b_eff;
    logic prop;

    always_comb begin
        b_eff  = b_bit ^ sub;
        prop   = a_bit ^ b_eff;
        p_mod  = en & prop;
        k_mod  = en & ~prop;
        g_one  = en & a_bit & b_eff;
        g_zero = en & ~a_bit & ~b_eff;
    end
endmodule

// File: rtl/drcla_lookahead.sv
module drcla_lookahead #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] p_mod,
    input  logic [WIDTH-1:0] g_one,
    input  logic [WIDTH-1:0] g_zero,
    input  logic             cin_t,
    input  logic             cin_f,
    output logic [WIDTH:0]   c_t,
    output logic [WIDTH:0]   c_f
);
    assign c_t[0] = cin_t;
    assign c_f[0] = cin_f;

    // Each carry is a flat sum of products over the lower bits and the carry-in.
    for (genvar i = 0; i < WIDTH; i++) begin : g_carry
        always_comb begin
            logic prod;
            logic acc_t;
            logic acc_f;
            prod  = 1'b1;
            acc_t = 1'b0;
            acc_f = 1'b0;
            for (int j = i; j >= 0; j--) begin
                acc_t = acc_t | (prod & g_one[j]);
                acc_f = acc_f | (prod & g_zero[j]);
                prod  = prod & p_mod[j];
            end
            c_t[i+1] = acc_t | (prod & cin_t);
            c_f[i+1] = acc_f | (prod & cin_f);
        end
    end
endmodule

// File: rtl/drcla_sumnet.sv
module drcla_sumnet #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] p_mod,
    input  logic [WIDTH-1:0] k_mod,
    input  logic [WIDTH-1:0] c_t,
    input  logic [WIDTH-1:0] c_f,
    output logic [WIDTH-1:0] s_t,
    output logic [WIDTH-1:0] s_f
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign s_t[i] = (p_mod[i] & c_f[i]) | (k_mod[i] & c_t[i]);
        assign s_f[i] = (p_mod[i] & c_t[i]) | (k_mod[i] & c_f[i]);
    end
endmodule

// File: rtl/drcla_complete.sv
module drcla_complete #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] s_t,
    input  logic [WIDTH-1:0] s_f,
    input  logic             co_t,
    input  logic             co_f,
    output logic             all_valid
);
    logic [WIDTH:0] bit_ok;

    for (genvar i = 0; i < WIDTH; i++) begin : g_det
        assign bit_ok[i] = s_t[i] ^ s_f[i];
    end
    assign bit_ok[WIDTH] = co_t ^ co_f;
    assign all_valid = &bit_ok;
endmodule

// File: rtl/dr_addsub_cla.sv
module dr_addsub_cla
    import dr_addsub_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             arith_mode,
    input  logic             add_sub,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] sum_t,
    output logic [WIDTH-1:0] sum_f,
    output logic             cout_t,
    output logic             cout_f,
    output logic             done
);
    localparam int CW = WIDTH + 1;

    logic             en;
    logic [WIDTH-1:0] p_mod, k_mod, g_one, g_zero;
    logic [CW-1:0]    c_t, c_f;
    logic [WIDTH-1:0] s_t, s_f;
    logic             all_valid;
    logic             primed;

    phase_e state, state_nx;

    assign en = go & arith_mode;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        drcla_slice u_slice (
            .a_bit (op_a[i]),
            .b_bit (op_b[i]),
            .sub   (add_sub),
            .en    (en),
            .p_mod (p_mod[i]),
            .k_mod (k_mod[i]),
            .g_one (g_one[i]),
            .g_zero(g_zero[i])
        );
    end

    drcla_lookahead #(.WIDTH(WIDTH)) u_cla (
        .p_mod (p_mod),
        .g_one (g_one),
        .g_zero(g_zero),
        .cin_t (en & add_sub),
        .cin_f (en & ~add_sub),
        .c_t   (c_t),
        .c_f   (c_f)
    );

    drcla_sumnet #(.WIDTH(WIDTH)) u_sum (
        .p_mod(p_mod),
        .k_mod(k_mod),
        .c_t  (c_t[WIDTH-1:0]),
        .c_f  (c_f[WIDTH-1:0]),
        .s_t  (s_t),
        .s_f  (s_f)
    );

    // Phase machine: next-state logic.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (en)  state_nx = ST_RESULT;
            ST_RESULT: if (!en) state_nx = ST_IDLE;
            default:            state_nx = ST_IDLE;
        endcase
    end

    // Phase machine: state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            primed <= 1'b0;
        end else begin
            state  <= state_nx;
            primed <= 1'b1;
        end
    end

    // Output register: loads the gated rails, which are null when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_t  <= '0;
            sum_f  <= '0;
            cout_t <= 1'b0;
            cout_f <= 1'b0;
        end else begin
            sum_t  <= s_t;
            sum_f  <= s_f;
            cout_t <= c_t[WIDTH];
            cout_f <= c_f[WIDTH];
        end
    end

    drcla_complete #(.WIDTH(WIDTH)) u_done (
        .s_t      (sum_t),
        .s_f      (sum_f),
        .co_t     (cout_t),
        .co_f     (cout_f),
        .all_valid(all_valid)
    );

    assign done = all_valid & (state == ST_RESULT);

    // R3: no illegal 11 code on any registered output pair
    p_no_illegal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((sum_t & sum_f) == '0) && !(cout_t && cout_f));

    // R3: no illegal 11 code on any internal carry pair
    p_carry_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_t & c_f) == '0);

    // R4, R5: disabled edge leaves every rail null
    p_null_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !$past(en)) |->
        (sum_t == '0 && sum_f == '0 && !cout_t && !cout_f && !done));

    // R6: an enabled edge always yields a complete result
    p_done_after_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(en)) |-> done);

    // R10: ST_RESULT is held only after an enabled edge
    p_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && state == ST_RESULT) |-> $past(en));
endmodule

// File: tb/dr_addsub_cla_test.sv
module dr_addsub_cla_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         go = 1'b0;
    logic         arith_mode = 1'b0;
    logic         add_sub = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [W-1:0] sum_t, sum_f;
    logic         cout_t, cout_f, done;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dr_addsub_cla #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .go(go), .arith_mode(arith_mode),
        .add_sub(add_sub), .op_a(op_a), .op_b(op_b),
        .sum_t(sum_t), .sum_f(sum_f), .cout_t(cout_t), .cout_f(cout_f),
        .done(done)
    );

    // {sub, a, b, expected {carry, sum}}
    localparam logic [25:0] VEC [10] = '{
        {1'b0, 8'h00, 8'h00, 9'h000},
        {1'b0, 8'hFF, 8'h01, 9'h100},
        {1'b0, 8'h5A, 8'h3C, 9'h096},
        {1'b0, 8'h80, 8'h80, 9'h100},
        {1'b0, 8'hFF, 8'hFF, 9'h1FE},
        {1'b1, 8'h10, 8'h01, 9'h10F},
        {1'b1, 8'h00, 8'h01, 9'h0FF},
        {1'b1, 8'h7F, 8'h7F, 9'h100},
        {1'b1, 8'h80, 8'h7F, 9'h101},
        {1'b1, 8'h3C, 8'hA5, 9'h097}
    };

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_null(input string req);
        check(sum_t == '0 && sum_f == '0, req, {16'h0, sum_t, sum_f}, 32'h0);
        check(!cout_t && !cout_f, req, {30'h0, cout_t, cout_f}, 32'h0);
        check(!done, req, {31'h0, done}, 32'h0);
    endtask

    task automatic run_op(input logic sub, input logic [W-1:0] a,
                          input logic [W-1:0] b, input logic [W:0] exp,
                          input string req);
        @(negedge clk);
        go = 1'b1; arith_mode = 1'b1; add_sub = sub; op_a = a; op_b = b;
        @(negedge clk);
        check(sum_t == exp[W-1:0] && sum_f == ~exp[W-1:0], req,
              {16'h0, sum_t, sum_f}, {16'h0, exp[W-1:0], ~exp[W-1:0]});
        check(cout_t == exp[W] && cout_f == ~exp[W], req,
              {30'h0, cout_t, cout_f}, {30'h0, exp[W], ~exp[W]});
        check(done, {req, " R6 done"}, {31'h0, done}, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R8: reset state, even with enable driven high
        go = 1'b1; arith_mode = 1'b1; op_a = 8'h12; op_b = 8'h34;
        repeat (3) @(negedge clk);
        check_null("R8 reset");
        @(negedge clk);
        rst_n = 1'b1; go = 1'b0;
        @(negedge clk);
        check_null("R4 go low after reset");

        // R1, R2, R9: table of vectors, back-to-back (R7)
        for (int i = 0; i < 10; i++) begin
            run_op(VEC[i][25], VEC[i][24:17], VEC[i][16:9], VEC[i][8:0],
                   VEC[i][25] ? "R1 table" : "R2 table");
        end

        // R7: back-to-back random operations
        for (int i = 0; i < 200; i++) begin
            logic [W-1:0] a, b;
            logic         s;
            logic [W:0]   e;
            a = W'($urandom);
            b = W'($urandom);
            s = 1'($urandom);
            e = {1'b0, a} + {1'b0, b ^ {W{s}}} + {{W{1'b0}}, s};
            run_op(s, a, b, e, s ? "R1 R7 random" : "R2 R7 random");
        end

        // R4: go low with valid operands gives null
        @(negedge clk);
        go = 1'b0; arith_mode = 1'b1; op_a = 8'hFF; op_b = 8'h01;
        @(negedge clk);
        check_null("R4 go low");

        // R10: re-entry after release
        run_op(1'b0, 8'h01, 8'h02, 9'h003, "R10 restart");

        // R5: non-arithmetic mode with go high gives null
        @(negedge clk);
        go = 1'b1; arith_mode = 1'b0; add_sub = 1'b1;
        @(negedge clk);
        check_null("R5 logic mode");

        // R9: full carry chain in both directions
        run_op(1'b0, 8'hFF, 8'h01, 9'h100, "R9 add chain");
        run_op(1'b1, 8'h00, 8'h00, 9'h100, "R9 sub chain");

        // R3: no 11 pair on outputs while active
        check((sum_t & sum_f) == '0 && !(cout_t && cout_f), "R3 encoding",
              {16'h0, sum_t & sum_f}, 32'h0);

        // R6: done falls after release
        @(negedge clk);
        go = 1'b0;
        @(negedge clk);
        check(!done, "R6 done release", {31'h0, done}, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule